// File: doc/BRIEF.md
# Instruction Pointer and Segment Mapper

This block is the fetch front end of a core whose program and data paths are separate but share one unified address space. It keeps the instruction pointer, which always holds the address of the next instruction to fetch. Each cycle with a fetch request, it issues that address and advances the pointer by one. Software writes, branches and interrupts act only by loading a new pointer value, and the fetch after that comes from the new location.

Both the pointer and the data-access address are decoded against three fixed address windows: flash, SRAM and utility ROM. Any address outside them is unmapped. Program fetches may use any of the three segments. Data accesses may use only flash and SRAM. One segment never serves both paths in the same cycle. When a fetch and a data access hit the same segment, the data access wins and the fetch stalls for that cycle, with the pointer held. All outputs are registered and appear one clock after the request.

Top module: `fetch_ip_mapper`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `ip_q` equals RESET_IP (0). Both select buses are zero, and `fetch_stall`, `fetch_err` and `data_err` are low.
- R2: Default windows are flash 0x0000–0x7FFF, utility ROM 0x8000–0x9FFF and SRAM 0xA000–0xAFFF. Everything from 0xB000 upward is unmapped. Select bit 0 is flash, bit 1 is SRAM and bit 2 is utility ROM.
- R3: A fetch request to a mapped pointer with no collision does three things one cycle later. It drives the one-hot `fetch_sel` of that segment. It presents the old pointer on `fetch_addr`. It raises `ip_q` by one.
- R4: With no fetch request and no load, `ip_q` holds and `fetch_sel` is zero.
- R5: An asserted `ipw_en` loads `ipw_data` into `ip_q` on the next edge. It takes priority over a redirect, over an increment and over a stall hold. The fetch made in that same cycle still uses the old pointer.
- R6: An asserted `redir_en` without `ipw_en` loads `redir_addr` into `ip_q`. It overrides the increment and the stall hold.
- R7: A data request to flash or SRAM drives the one-hot `data_sel` of that segment and `data_addr_q` one cycle later.
- R8: A data request to utility ROM or to an unmapped address raises `data_err` one cycle later. In that case `data_sel` is zero and no collision can be caused.
- R9: When a granted data access and a mapped fetch target the same segment, `data_sel` is driven, `fetch_sel` is zero, `fetch_stall` is high and `ip_q` holds, unless a load is pending.
- R10: `fetch_sel` and `data_sel` never share a set bit.
- R11: A fetch request whose pointer is unmapped raises `fetch_err` one cycle later. In that case `fetch_sel` is zero and `ip_q` holds, unless a load is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | input | 1 | Request a fetch from the current pointer |
| data_req | input | 1 | Request a data access |
| data_addr | input | AW | Unified data address |
| ipw_en | input | 1 | Software write to the pointer |
| ipw_data | input | AW | Value for the software write |
| redir_en | input | 1 | Branch or interrupt redirect |
| redir_addr | input | AW | Redirect target |
| ip_q | output | AW | Current instruction pointer (readable by software) |
| fetch_addr | output | AW | Registered fetch address |
| fetch_sel | output | 3 | Registered one-hot fetch segment select |
| fetch_stall | output | 1 | Fetch lost a segment collision |
| fetch_err | output | 1 | Fetch pointer unmapped |
| data_addr_q | output | AW | Registered data address |
| data_sel | output | 3 | Registered one-hot data segment select |
| data_err | output | 1 | Data access to a forbidden or unmapped range |

## Verification
The bench builds the block with its default parameters: a 16-bit address, the three windows listed in R2 and a reset pointer of zero. These defaults put every window edge within reach, along with the unmapped top of the space. Loads can then move the pointer straight into each segment, so fetches from utility ROM, SRAM and unmapped space can be tried next to collisions on flash and SRAM. Priority is exercised by cases where a write, a redirect, a stall and an error land in the same cycle.

// File: rtl/fim_pkg.sv
package fim_pkg;
  localparam int NSEG = 3;
  localparam int SEG_FLASH = 0;
  localparam int SEG_SRAM  = 1;
  localparam int SEG_UROM  = 2;
  typedef logic [NSEG-1:0] seg_sel_t;
endpackage

// File: rtl/fim_seg_decode.sv
module fim_seg_decode
  import fim_pkg::*;
#(
  parameter int AW = 16,
  parameter logic [AW-1:0] FLASH_LO = 'h0000,
  parameter logic [AW-1:0] FLASH_HI = 'h7FFF,
  parameter logic [AW-1:0] SRAM_LO  = 'hA000,
  parameter logic [AW-1:0] SRAM_HI  = 'hAFFF,
  parameter logic [AW-1:0] UROM_LO  = 'h8000,
  parameter logic [AW-1:0] UROM_HI  = 'h9FFF
) (
  input  logic [AW-1:0] addr,
  output seg_sel_t      sel,
  output logic          miss
);
  localparam logic [AW-1:0] LO [NSEG] = '{FLASH_LO, SRAM_LO, UROM_LO};
  localparam logic [AW-1:0] HI [NSEG] = '{FLASH_HI, SRAM_HI, UROM_HI};

  for (genvar g = 0; g < NSEG; g++) begin : g_win
    assign sel[g] = (addr >= LO[g]) && (addr <= HI[g]);
  end

  assign miss = ~|sel;

  // R2
  always_comb begin
    windows_disjoint_chk: assert ($onehot0(sel));
  end
endmodule

// File: rtl/fim_path_arb.sv
module fim_path_arb
  import fim_pkg::*;
#(
  parameter seg_sel_t DATA_MASK = 3'b011
) (
  input  logic     fetch_req,
  input  seg_sel_t fetch_hit,
  input  logic     fetch_miss,
  input  logic     data_req,
  input  seg_sel_t data_hit,
  input  logic     data_miss,
  output logic     fetch_go,
  output logic     data_go,
  output logic     fetch_bad,
  output logic     data_bad,
  output logic     collide
);
  logic fetch_ok;

  assign fetch_ok  = fetch_req && !fetch_miss;
  assign data_go   = data_req && !data_miss && |(data_hit & DATA_MASK);
  assign data_bad  = data_req && !data_go;
  assign fetch_bad = fetch_req && fetch_miss;
  assign collide   = fetch_ok && data_go && |(fetch_hit & data_hit);
  assign fetch_go  = fetch_ok && !collide;

  // R10
  always_comb begin
    one_owner_chk: assert (!(fetch_go && data_go) || ((fetch_hit & data_hit) == '0));
  end
endmodule

// File: rtl/fim_ip_ctrl.sv
module fim_ip_ctrl #(
  parameter int AW = 16,
  parameter logic [AW-1:0] RESET_IP = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          advance,
  input  logic          ipw_en,
  input  logic [AW-1:0] ipw_data,
  input  logic          redir_en,
  input  logic [AW-1:0] redir_addr,
  output logic [AW-1:0] ip
);
  logic [AW-1:0] ip_next;

  always_comb begin
    if (ipw_en)        ip_next = ipw_data;
    else if (redir_en) ip_next = redir_addr;
    else if (advance)  ip_next = ip + AW'(1);
    else               ip_next = ip;
  end

  always_ff @(posedge clk) begin
    if (rst) ip <= RESET_IP;
    else     ip <= ip_next;
  end

  // R4
  ip_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!advance && !ipw_en && !redir_en) |=> $stable(ip));
  // R6
  redir_load_chk: assert property (@(posedge clk) disable iff (rst)
    (redir_en && !ipw_en) |=> ip == $past(redir_addr));
endmodule

// File: rtl/fetch_ip_mapper.sv
module fetch_ip_mapper
  import fim_pkg::*;
#(
  parameter int AW = 16,
  parameter logic [AW-1:0] RESET_IP = '0,
  parameter logic [AW-1:0] FLASH_LO = 'h0000,
  parameter logic [AW-1:0] FLASH_HI = 'h7FFF,
  parameter logic [AW-1:0] SRAM_LO  = 'hA000,
  parameter logic [AW-1:0] SRAM_HI  = 'hAFFF,
  parameter logic [AW-1:0] UROM_LO  = 'h8000,
  parameter logic [AW-1:0] UROM_HI  = 'h9FFF,
  parameter logic [2:0]    DATA_MASK = 3'b011
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fetch_req,
  input  logic          data_req,
  input  logic [AW-1:0] data_addr,
  input  logic          ipw_en,
  input  logic [AW-1:0] ipw_data,
  input  logic          redir_en,
  input  logic [AW-1:0] redir_addr,
  output logic [AW-1:0] ip_q,
  output logic [AW-1:0] fetch_addr,
  output logic [2:0]    fetch_sel,
  output logic          fetch_stall,
  output logic          fetch_err,
  output logic [AW-1:0] data_addr_q,
  output logic [2:0]    data_sel,
  output logic          data_err
);
  seg_sel_t f_hit, d_hit;
  logic     f_miss, d_miss;
  logic     f_go, d_go, f_bad, d_bad, clash;

  fim_seg_decode #(
    .AW(AW), .FLASH_LO(FLASH_LO), .FLASH_HI(FLASH_HI), .SRAM_LO(SRAM_LO),
    .SRAM_HI(SRAM_HI), .UROM_LO(UROM_LO), .UROM_HI(UROM_HI)
  ) u_fdec (.addr(ip_q), .sel(f_hit), .miss(f_miss));

  fim_seg_decode #(
    .AW(AW), .FLASH_LO(FLASH_LO), .FLASH_HI(FLASH_HI), .SRAM_LO(SRAM_LO),
    .SRAM_HI(SRAM_HI), .UROM_LO(UROM_LO), .UROM_HI(UROM_HI)
  ) u_ddec (.addr(data_addr), .sel(d_hit), .miss(d_miss));

  fim_path_arb #(.DATA_MASK(DATA_MASK)) u_arb (
    .fetch_req(fetch_req), .fetch_hit(f_hit), .fetch_miss(f_miss),
    .data_req(data_req), .data_hit(d_hit), .data_miss(d_miss),
    .fetch_go(f_go), .data_go(d_go), .fetch_bad(f_bad), .data_bad(d_bad),
    .collide(clash)
  );

  fim_ip_ctrl #(.AW(AW), .RESET_IP(RESET_IP)) u_ip (
    .clk(clk), .rst(rst), .advance(f_go),
    .ipw_en(ipw_en), .ipw_data(ipw_data),
    .redir_en(redir_en), .redir_addr(redir_addr), .ip(ip_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_addr  <= '0;
      fetch_sel   <= '0;
      fetch_stall <= 1'b0;
      fetch_err   <= 1'b0;
      data_addr_q <= '0;
      data_sel    <= '0;
      data_err    <= 1'b0;
    end else begin
      fetch_addr  <= ip_q;
      fetch_sel   <= f_go ? f_hit : '0;
      fetch_stall <= clash;
      fetch_err   <= f_bad;
      data_addr_q <= data_addr;
      data_sel    <= d_go ? d_hit : '0;
      data_err    <= d_bad;
    end
  end

  // R10
  no_shared_seg_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_sel & data_sel) == '0);
  // R9
  stall_shape_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_stall |-> (fetch_sel == '0) && (data_sel != '0));
  // R3
  advance_by_one_chk: assert property (@(posedge clk) disable iff (rst)
    ((fetch_sel != '0) && !$past(ipw_en) && !$past(redir_en)) |-> ip_q == fetch_addr + AW'(1));
  // R5
  sw_write_chk: assert property (@(posedge clk) disable iff (rst)
    ipw_en |=> ip_q == $past(ipw_data));
  // R8
  data_err_chk: assert property (@(posedge clk) disable iff (rst)
    data_err |-> data_sel == '0);
  // R11
  fetch_err_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_err |-> (fetch_sel == '0) && !fetch_stall);
endmodule

// File: tb/fetch_ip_mapper_tb.sv
module fetch_ip_mapper_tb;
  localparam int AW = 16;

  typedef struct packed {
    logic          freq;
    logic          dreq;
    logic [AW-1:0] daddr;
    logic          wen;
    logic [AW-1:0] wdat;
    logic          ren;
    logic [AW-1:0] raddr;
    logic [AW-1:0] e_ip;
    logic [2:0]    e_fsel;
    logic [AW-1:0] e_faddr;
    logic [2:0]    e_dsel;
    logic          e_stall;
    logic          e_ferr;
    logic          e_derr;
    logic [3:0]    rq;
  } vec_t;

  function automatic vec_t mk(logic f, logic d, logic [AW-1:0] da, logic w, logic [AW-1:0] wd,
                              logic r, logic [AW-1:0] ra, logic [AW-1:0] ip, logic [2:0] fs,
                              logic [AW-1:0] fa, logic [2:0] ds, logic st, logic fe, logic de,
                              logic [3:0] rq);
    mk = '{f, d, da, w, wd, r, ra, ip, fs, fa, ds, st, fe, de, rq};
  endfunction

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    mk(1,0,'h0000,0,'h0000,0,'h0000,'h0001,3'b001,'h0000,3'b000,0,0,0,3),  // R3 flash fetch
    mk(1,1,'hA010,0,'h0000,0,'h0000,'h0002,3'b001,'h0001,3'b010,0,0,0,7),  // R7 parallel paths
    mk(1,1,'h0100,0,'h0000,0,'h0000,'h0002,3'b000,'h0002,3'b001,1,0,0,9),  // R9 flash clash
    mk(1,0,'h0000,1,'h8000,0,'h0000,'h8000,3'b001,'h0002,3'b000,0,0,0,5),  // R5 write vs increment
    mk(1,0,'h0000,0,'h0000,0,'h0000,'h8001,3'b100,'h8000,3'b000,0,0,0,2),  // R2 urom fetch
    mk(1,1,'h8004,0,'h0000,0,'h0000,'h8002,3'b100,'h8001,3'b000,0,0,1,8),  // R8 urom data refused
    mk(1,0,'h0000,0,'h0000,1,'hA000,'hA000,3'b100,'h8002,3'b000,0,0,0,6),  // R6 redirect
    mk(1,1,'hA123,0,'h0000,0,'h0000,'hA000,3'b000,'hA000,3'b010,1,0,0,9),  // R9 sram clash
    mk(1,0,'h0000,1,'h1234,1,'h5555,'h1234,3'b010,'hA000,3'b000,0,0,0,5),  // R5 write beats redirect
    mk(0,1,'hC000,0,'h0000,0,'h0000,'h1234,3'b000,'h1234,3'b000,0,0,1,8),  // R8 unmapped data
    mk(0,0,'h0000,0,'h0000,1,'hB000,'hB000,3'b000,'h1234,3'b000,0,0,0,6),  // R6 redirect idle
    mk(1,0,'h0000,0,'h0000,0,'h0000,'hB000,3'b000,'hB000,3'b000,0,1,0,11), // R11 unmapped fetch
    mk(1,0,'h0000,0,'h0000,1,'h0010,'h0010,3'b000,'hB000,3'b000,0,1,0,6),  // R6 redirect over error hold
    mk(1,1,'h0020,1,'h0400,0,'h0000,'h0400,3'b000,'h0010,3'b001,1,0,0,5),  // R5 write over stall
    mk(1,0,'h0000,0,'h0000,0,'h0000,'h0401,3'b001,'h0400,3'b000,0,0,0,3)   // R3
  };

  logic          clk = 1'b0;
  logic          rst;
  logic          fetch_req, data_req, ipw_en, redir_en;
  logic [AW-1:0] data_addr, ipw_data, redir_addr;
  logic [AW-1:0] ip_q, fetch_addr, data_addr_q;
  logic [2:0]    fetch_sel, data_sel;
  logic          fetch_stall, fetch_err, data_err;
  int            checks = 0;
  int            errors = 0;
  logic          done = 1'b0;

  always #2.5 clk = ~clk;

  fetch_ip_mapper #(.AW(AW)) u_dut (
    .clk(clk), .rst(rst), .fetch_req(fetch_req), .data_req(data_req),
    .data_addr(data_addr), .ipw_en(ipw_en), .ipw_data(ipw_data),
    .redir_en(redir_en), .redir_addr(redir_addr), .ip_q(ip_q),
    .fetch_addr(fetch_addr), .fetch_sel(fetch_sel), .fetch_stall(fetch_stall),
    .fetch_err(fetch_err), .data_addr_q(data_addr_q), .data_sel(data_sel),
    .data_err(data_err)
  );

  task automatic idle_inputs();
    fetch_req = 0; data_req = 0; data_addr = '0; ipw_en = 0;
    ipw_data = '0; redir_en = 0; redir_addr = '0;
  endtask

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(vec_t v);
    @(negedge clk);
    fetch_req = v.freq; data_req = v.dreq; data_addr = v.daddr;
    ipw_en = v.wen; ipw_data = v.wdat; redir_en = v.ren; redir_addr = v.raddr;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic check_reset_state();
    // R1
    check("R1 ip", 64'(ip_q), 64'h0);
    check("R1 outputs", {58'h0, fetch_sel, data_sel}, 64'h0);
    check("R1 flags", {61'h0, fetch_stall, fetch_err, data_err}, 64'h0);
  endtask

  task automatic data_probe(logic [AW-1:0] a, logic [2:0] es, logic ee);
    vec_t v;
    v = mk(0,1,a,0,'0,0,'0,'0,'0,'0,es,0,0,ee,2);
    apply(v);
    // R2 window edges, R7 and R8 on data path
    check("R2 data_sel", 64'(data_sel), 64'(es));
    check("R8 data_err", 64'(data_err), 64'(ee));
    if (es != 0) check("R7 data_addr_q", 64'(data_addr_q), 64'(a));
  endtask

  initial begin
    idle_inputs();
    rst = 1;
    repeat (3) @(negedge clk);
    check_reset_state();
    rst = 0;
    @(negedge clk);
    check_reset_state();

    for (int i = 0; i < NV; i++) begin
      string tg;
      apply(VEC[i]);
      tg = $sformatf("R%0d vec%0d", VEC[i].rq, i);
      check({tg, " ip"}, 64'(ip_q), 64'(VEC[i].e_ip));
      check({tg, " fsel"}, 64'(fetch_sel), 64'(VEC[i].e_fsel));
      check({tg, " dsel"}, 64'(data_sel), 64'(VEC[i].e_dsel));
      check({tg, " flags"}, {61'h0, fetch_stall, fetch_err, data_err},
            {61'h0, VEC[i].e_stall, VEC[i].e_ferr, VEC[i].e_derr});
      if (VEC[i].e_fsel != 0) check({tg, " faddr"}, 64'(fetch_addr), 64'(VEC[i].e_faddr));
      // R10
      check({tg, " R10 disjoint"}, 64'(fetch_sel & data_sel), 64'h0);
    end

    // R4 idle hold
    @(negedge clk);
    check("R4 hold ip", 64'(ip_q), 64'h0401);
    check("R4 no fetch", 64'(fetch_sel), 64'h0);

    data_probe('h7FFF, 3'b001, 0);
    data_probe('h8000, 3'b000, 1);
    data_probe('h9FFF, 3'b000, 1);
    data_probe('hA000, 3'b010, 0);
    data_probe('hAFFF, 3'b010, 0);
    data_probe('hB000, 3'b000, 1);

    // R1 reset mid-run
    @(negedge clk);
    fetch_req = 1; rst = 1;
    @(negedge clk);
    @(negedge clk);
    check_reset_state();
    rst = 0; fetch_req = 0;
    @(negedge clk);
    check_reset_state();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule